// File: doc/BRIEF.md
# Data Address Generator and Decoder

This block forms the effective data-space address for a load or store. It picks one of five addressing modes: an absolute address taken from the instruction, a plain pointer, a pointer plus a small unsigned offset, a pointer decremented before use, and a pointer incremented after use. It reads the current values of the three 16-bit pointer pairs (X, Y and Z) that sit in the upper six working registers. When a mode changes a pointer, it returns the new pointer value together with a write-back strobe and the pointer's identity.

The resulting address is then sorted into one of three regions. The working registers sit at 0x0000-0x001F. The I/O registers sit at 0x0020-0x005F. The 128-byte internal SRAM sits at 0x0060-0x00DF. The block reports a one-hot region select and the index of the location inside that region. Anything above the SRAM raises an out-of-range flag. All outputs are registered, so the result of a request presented in one cycle appears after the next rising clock edge.

Top module: `dag_top`

## Requirements
- R1: While rst_n is low, every output is 0.
- R2: Results are registered: a request sampled at a rising edge with acc_en=1 appears on the outputs after that edge, with acc_vld=1 when the request is legal.
- R3: Direct mode (mode=0) gives eff_addr=dir_addr, ignores ptr_sel (even the value 3) and raises no write-back.
- R4: Indirect mode (mode=1) gives eff_addr equal to the selected pointer (ptr_sel 0=X, 1=Y, 2=Z) and raises no write-back.
- R5: Displacement mode (mode=2) with Y or Z gives eff_addr = pointer + disp, where disp is an unsigned 6-bit value from 0 to 63; there is no write-back.
- R6: Displacement mode with X, ptr_sel=3 in any pointer mode, and mode codes 5-7 set illegal=1 and acc_vld=0, with no write-back, no region select and no out-of-range flag.
- R7: Pre-decrement mode (mode=3) gives eff_addr = pointer-1 and ptr_new = pointer-1, with ptr_wb=1 and ptr_wb_sel=ptr_sel.
- R8: Post-increment mode (mode=4) gives eff_addr = the original pointer and ptr_new = pointer+1, with ptr_wb=1 and ptr_wb_sel=ptr_sel.
- R9: Pointer and offset arithmetic wraps modulo 65536 (0x0000-1 = 0xFFFF, 0xFFFF+1 = 0x0000, 0xFFF0+0x3F = 0x002F).
- R10: Addresses 0x0000-0x001F assert sel_reg, with loc_idx equal to the register number (the address).
- R11: Addresses 0x0020-0x005F assert sel_io, with loc_idx = address - 0x20.
- R12: Addresses 0x0060-0x00DF assert sel_sram, with loc_idx = address - 0x60.
- R13: Addresses above 0x00DF set out_of_range=1 with no region select and loc_idx=0. Any pointer write-back still takes place.
- R14: With acc_en=0, the next cycle shows acc_vld, ptr_wb, all selects, out_of_range and illegal at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Request an address this cycle |
| mode | input | 3 | 0 direct, 1 indirect, 2 displacement, 3 pre-decrement, 4 post-increment |
| ptr_sel | input | 2 | 0 X, 1 Y, 2 Z, 3 reserved |
| dir_addr | input | 16 | Absolute address for direct mode |
| disp | input | 6 | Unsigned offset for displacement mode |
| x_val | input | 16 | Current X pointer |
| y_val | input | 16 | Current Y pointer |
| z_val | input | 16 | Current Z pointer |
| acc_vld | output | 1 | Legal access result present |
| eff_addr | output | 16 | Effective data-space address |
| ptr_wb | output | 1 | Pointer write-back strobe |
| ptr_wb_sel | output | 2 | Pointer that is written back |
| ptr_new | output | 16 | Updated pointer value |
| sel_reg | output | 1 | Working-register region selected |
| sel_io | output | 1 | I/O region selected |
| sel_sram | output | 1 | SRAM region selected |
| loc_idx | output | 7 | Index inside the selected region |
| out_of_range | output | 1 | Address above the SRAM |
| illegal | output | 1 | Illegal mode and pointer pairing |

## Verification
Each mode is driven with X, Y and Z holding different values. This shows that the correct pointer is picked and that direct mode really ignores ptr_sel. Pointer values at 0x0000 and 0xFFFF, and a large offset near the top, show whether the arithmetic wraps at 16 bits. Addresses on both sides of 0x1F/0x20, 0x5F/0x60 and 0xDF/0xE0 tell the three regions apart and check each region's index offset. Illegal pairings and idle cycles come between legal requests, so a stale result cannot pass as a fresh one.

// File: rtl/dag_pkg.sv
package dag_pkg;
    parameter int AW     = 16;
    parameter int DISP_W = 6;
    parameter int IDX_W  = 7;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } am_mode_e;

    typedef enum logic [1:0] {
        PS_X   = 2'd0,
        PS_Y   = 2'd1,
        PS_Z   = 2'd2,
        PS_RSV = 2'd3
    } ptr_sel_e;

    typedef struct packed {
        logic              acc_vld;
        logic [AW-1:0]     eff_addr;
        logic              ptr_wb;
        logic [1:0]        ptr_wb_sel;
        logic [AW-1:0]     ptr_new;
        logic              sel_reg;
        logic              sel_io;
        logic              sel_sram;
        logic [IDX_W-1:0]  loc_idx;
        logic              out_of_range;
        logic              illegal;
    } dag_out_s;
endpackage

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
    import dag_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int OFS_W  = DISP_W
) (
    input  logic [2:0]        mode,
    input  logic [1:0]        ptr_sel,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [OFS_W-1:0]  disp,
    input  logic [ADDR_W-1:0] x_val,
    input  logic [ADDR_W-1:0] y_val,
    input  logic [ADDR_W-1:0] z_val,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] ptr_upd,
    output logic              wb,
    output logic              bad
);
    localparam int PAD_W = ADDR_W - OFS_W;
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] ptr;
    logic              ptr_ok;
    logic [ADDR_W-1:0] ofs_ext;

    assign ofs_ext = {{PAD_W{1'b0}}, disp};

    always_comb begin
        ptr_ok = 1'b1;
        unique case (ptr_sel)
            PS_X:    ptr = x_val;
            PS_Y:    ptr = y_val;
            PS_Z:    ptr = z_val;
            default: begin ptr = '0; ptr_ok = 1'b0; end
        endcase
    end

    always_comb begin
        addr    = '0;
        ptr_upd = '0;
        wb      = 1'b0;
        bad     = 1'b0;
        unique case (mode)
            AM_DIRECT: addr = dir_addr;
            AM_IND: begin
                addr = ptr;
                bad  = !ptr_ok;
            end
            AM_DISP: begin
                addr = ptr + ofs_ext;
                bad  = !ptr_ok || (ptr_sel == PS_X);
            end
            AM_PREDEC: begin
                addr    = ptr - ONE;
                ptr_upd = ptr - ONE;
                wb      = 1'b1;
                bad     = !ptr_ok;
            end
            AM_POSTINC: begin
                addr    = ptr;
                ptr_upd = ptr + ONE;
                wb      = 1'b1;
                bad     = !ptr_ok;
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/dag_region_dec.sv
module dag_region_dec
    import dag_pkg::*;
#(
    parameter int ADDR_W   = AW,
    parameter int REG_CNT  = 32,
    parameter int IO_CNT   = 64,
    parameter int SRAM_CNT = 128,
    parameter int LIDX_W   = IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_reg,
    output logic              in_io,
    output logic              in_sram,
    output logic              oor,
    output logic [LIDX_W-1:0] idx
);
    localparam logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(REG_CNT);
    localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(REG_CNT + IO_CNT);
    localparam logic [ADDR_W-1:0] TOP_END   = ADDR_W'(REG_CNT + IO_CNT + SRAM_CNT);

    logic [LIDX_W-1:0] a_lo;
    assign a_lo = addr[LIDX_W-1:0];

    always_comb begin
        in_reg  = addr < IO_BASE;
        in_io   = !in_reg && (addr < SRAM_BASE);
        in_sram = (addr >= SRAM_BASE) && (addr < TOP_END);
        oor     = addr >= TOP_END;
        if (in_reg)
            idx = a_lo;
        else if (in_io)
            idx = a_lo - IO_BASE[LIDX_W-1:0];
        else if (in_sram)
            idx = a_lo - SRAM_BASE[LIDX_W-1:0];
        else
            idx = '0;
    end
endmodule

// File: rtl/dag_top.sv
module dag_top
    import dag_pkg::*;
#(
    parameter int ADDR_W   = AW,
    parameter int OFS_W    = DISP_W,
    parameter int REG_CNT  = 32,
    parameter int IO_CNT   = 64,
    parameter int SRAM_CNT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [2:0]        mode,
    input  logic [1:0]        ptr_sel,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [OFS_W-1:0]  disp,
    input  logic [ADDR_W-1:0] x_val,
    input  logic [ADDR_W-1:0] y_val,
    input  logic [ADDR_W-1:0] z_val,
    output logic              acc_vld,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              ptr_wb,
    output logic [1:0]        ptr_wb_sel,
    output logic [ADDR_W-1:0] ptr_new,
    output logic              sel_reg,
    output logic              sel_io,
    output logic              sel_sram,
    output logic [IDX_W-1:0]  loc_idx,
    output logic              out_of_range,
    output logic              illegal
);
    logic [ADDR_W-1:0] c_addr, c_ptr;
    logic              c_wb, c_bad;
    logic              r_reg, r_io, r_sram, r_oor;
    logic [IDX_W-1:0]  r_idx;
    dag_out_s          out_d, out_q;

    dag_addr_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_calc (
        .mode(mode), .ptr_sel(ptr_sel), .dir_addr(dir_addr), .disp(disp),
        .x_val(x_val), .y_val(y_val), .z_val(z_val),
        .addr(c_addr), .ptr_upd(c_ptr), .wb(c_wb), .bad(c_bad)
    );

    dag_region_dec #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT), .IO_CNT(IO_CNT),
                     .SRAM_CNT(SRAM_CNT), .LIDX_W(IDX_W)) u_dec (
        .addr(c_addr), .in_reg(r_reg), .in_io(r_io), .in_sram(r_sram),
        .oor(r_oor), .idx(r_idx)
    );

    always_comb begin
        out_d = '0;
        if (acc_en) begin
            if (c_bad) begin
                out_d.illegal = 1'b1;
            end else begin
                out_d.acc_vld      = 1'b1;
                out_d.eff_addr     = c_addr;
                out_d.ptr_wb       = c_wb;
                out_d.ptr_wb_sel   = c_wb ? ptr_sel : 2'd0;
                out_d.ptr_new      = c_ptr;
                out_d.sel_reg      = r_reg;
                out_d.sel_io       = r_io;
                out_d.sel_sram     = r_sram;
                out_d.loc_idx      = r_idx;
                out_d.out_of_range = r_oor;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign acc_vld      = out_q.acc_vld;
    assign eff_addr     = out_q.eff_addr;
    assign ptr_wb       = out_q.ptr_wb;
    assign ptr_wb_sel   = out_q.ptr_wb_sel;
    assign ptr_new      = out_q.ptr_new;
    assign sel_reg      = out_q.sel_reg;
    assign sel_io       = out_q.sel_io;
    assign sel_sram     = out_q.sel_sram;
    assign loc_idx      = out_q.loc_idx;
    assign out_of_range = out_q.out_of_range;
    assign illegal      = out_q.illegal;

    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!acc_vld && !ptr_wb && !sel_reg && !sel_io && !sel_sram && !out_of_range));
    a_r13_oor_no_region: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (!sel_reg && !sel_io && !sel_sram));
    a_r10_region_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_reg, sel_io, sel_sram, out_of_range}));
    a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (!acc_vld && !ptr_wb && !illegal));
    a_r8_post_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && ptr_wb && (eff_addr + 16'd1 == ptr_new)) |-> !sel_reg || (eff_addr < 16'h0020));
    a_r12_sram_idx: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sram |-> (eff_addr >= 16'h0060 && eff_addr <= 16'h00DF));
endmodule

// File: tb/tb_dag_top.sv
module tb_dag_top;
    logic clk = 1'b0, rst_n = 1'b0, acc_en = 1'b0;
    logic [2:0] mode = '0;
    logic [1:0] ptr_sel = '0;
    logic [15:0] dir_addr = '0, x_val = '0, y_val = '0, z_val = '0;
    logic [5:0] disp = '0;
    logic acc_vld, ptr_wb, sel_reg, sel_io, sel_sram, out_of_range, illegal;
    logic [15:0] eff_addr, ptr_new;
    logic [1:0] ptr_wb_sel;
    logic [6:0] loc_idx;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    dag_top dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic req(input logic [2:0] m, input logic [1:0] p, input logic [15:0] d, input logic [5:0] o);
        @(negedge clk);
        acc_en = 1'b1; mode = m; ptr_sel = p; dir_addr = d; disp = o;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic chk_region(input string rq, input logic [15:0] a);
        if (a < 16'h20) begin
            chk(sel_reg && !sel_io && !sel_sram && !out_of_range, rq, {sel_reg,sel_io,sel_sram}, 4);
            chk(loc_idx == a[6:0], rq, loc_idx, a);
        end else if (a < 16'h60) begin
            chk(!sel_reg && sel_io && !sel_sram && !out_of_range, rq, {sel_reg,sel_io,sel_sram}, 2);
            chk(loc_idx == 7'(a - 16'h20), rq, loc_idx, a - 16'h20);
        end else if (a < 16'hE0) begin
            chk(!sel_reg && !sel_io && sel_sram && !out_of_range, rq, {sel_reg,sel_io,sel_sram}, 1);
            chk(loc_idx == 7'(a - 16'h60), rq, loc_idx, a - 16'h60);
        end else begin
            chk(!sel_reg && !sel_io && !sel_sram && out_of_range, rq, {sel_reg,sel_io,sel_sram,out_of_range}, 1);
            chk(loc_idx == 0, rq, loc_idx, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!acc_vld && eff_addr == 0 && !ptr_wb && ptr_new == 0 && !illegal && !out_of_range
            && !sel_reg && !sel_io && !sel_sram && loc_idx == 0, "R1", eff_addr, 0);
    endtask

    task automatic t_direct();
        req(3'd0, 2'd3, 16'h0045, 6'd0);
        chk(acc_vld && !illegal, "R2", acc_vld, 1);
        chk(eff_addr == 16'h0045 && !ptr_wb, "R3", eff_addr, 16'h45);
        chk_region("R11", 16'h0045);
        req(3'd0, 2'd0, 16'h1234, 6'd0);
        chk(eff_addr == 16'h1234 && !ptr_wb, "R3", eff_addr, 16'h1234);
        chk_region("R13", 16'h1234);
    endtask

    task automatic t_indirect();
        x_val = 16'h001F; y_val = 16'h0020; z_val = 16'h0060;
        req(3'd1, 2'd0, 16'hFFFF, 6'd0);
        chk(acc_vld && eff_addr == 16'h001F && !ptr_wb, "R4", eff_addr, 16'h1F);
        chk_region("R10", 16'h001F);
        req(3'd1, 2'd1, 16'hFFFF, 6'd0);
        chk(eff_addr == 16'h0020, "R4", eff_addr, 16'h20);
        chk_region("R11", 16'h0020);
        req(3'd1, 2'd2, 16'hFFFF, 6'd0);
        chk(eff_addr == 16'h0060, "R4", eff_addr, 16'h60);
        chk_region("R12", 16'h0060);
    endtask

    task automatic t_disp();
        y_val = 16'h00A0; z_val = 16'hFFF0;
        req(3'd2, 2'd1, 16'h0, 6'd63);
        chk(acc_vld && eff_addr == 16'h00DF && !ptr_wb, "R5", eff_addr, 16'hDF);
        chk_region("R12", 16'h00DF);
        req(3'd2, 2'd2, 16'h0, 6'd63);
        chk(eff_addr == 16'h002F, "R9", eff_addr, 16'h2F);
        chk_region("R11", 16'h002F);
    endtask

    task automatic t_illegal();
        req(3'd2, 2'd0, 16'h0, 6'd1);
        chk(illegal && !acc_vld && !ptr_wb && !sel_reg && !sel_io && !sel_sram && !out_of_range,
            "R6", {illegal, acc_vld}, 2);
        req(3'd3, 2'd3, 16'h0, 6'd0);
        chk(illegal && !acc_vld && !ptr_wb, "R6", {illegal, acc_vld}, 2);
        req(3'd6, 2'd1, 16'h0, 6'd0);
        chk(illegal && !acc_vld && !ptr_wb, "R6", {illegal, acc_vld}, 2);
    endtask

    task automatic t_predec();
        x_val = 16'h0060; y_val = 16'h0000;
        req(3'd3, 2'd0, 16'h0, 6'd0);
        chk(eff_addr == 16'h005F && ptr_new == 16'h005F, "R7", eff_addr, 16'h5F);
        chk(ptr_wb && ptr_wb_sel == 2'd0, "R7", ptr_wb_sel, 0);
        chk_region("R11", 16'h005F);
        req(3'd3, 2'd1, 16'h0, 6'd0);
        chk(eff_addr == 16'hFFFF && ptr_new == 16'hFFFF && ptr_wb && ptr_wb_sel == 2'd1, "R9", ptr_new, 16'hFFFF);
        chk_region("R13", 16'hFFFF);
    endtask

    task automatic t_postinc();
        z_val = 16'h00DF; x_val = 16'hFFFF;
        req(3'd4, 2'd2, 16'h0, 6'd0);
        chk(eff_addr == 16'h00DF && ptr_new == 16'h00E0, "R8", ptr_new, 16'hE0);
        chk(ptr_wb && ptr_wb_sel == 2'd2, "R8", ptr_wb_sel, 2);
        chk_region("R12", 16'h00DF);
        req(3'd4, 2'd0, 16'h0, 6'd0);
        chk(eff_addr == 16'hFFFF && ptr_new == 16'h0000 && ptr_wb, "R9", ptr_new, 0);
        chk(out_of_range && acc_vld, "R13", out_of_range, 1);
        z_val = 16'h00E0;
        req(3'd1, 2'd2, 16'h0, 6'd0);
        chk_region("R13", 16'h00E0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_en = 1'b0; mode = 3'd3; ptr_sel = 2'd1;
        @(posedge clk);
        @(negedge clk);
        chk(!acc_vld && !ptr_wb && !illegal && !out_of_range && !sel_reg && !sel_io && !sel_sram,
            "R14", {acc_vld, ptr_wb}, 0);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        acc_en = 1'b1; mode = 3'd4; x_val = 16'h0050;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1; acc_en = 1'b0;
        t_direct();
        t_indirect();
        t_disp();
        t_illegal();
        t_predec();
        t_idle();
        t_postinc();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule